// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a windowed watchdog with a 7-bit down-counter. It protects a system against software that either stalls or runs too fast. A tick generator divides the peripheral clock in two steps. The first is a free-running stage of 2^FIX_DIV_W cycles. The second is a programmable power-of-two stage chosen by a prescaler exponent. Each tick steps the counter down by one.

Software arms the watchdog by writing the control word with the enable bit set. It keeps the system alive by rewriting the counter. That rewrite, the refresh, is only legal once the count has fallen to or below the programmed window value. The block fires a one-cycle system reset in any of three cases:

- the counter steps past 0x40;
- software loads a value with bit 6 clear while armed;
- software refreshes too early.

An early-warning flag sets one tick before expiry. It drives an interrupt line when the interrupt enable is set. Once armed, the watchdog cannot be disarmed. Only its own reset pulse or `rst_ni` returns it to the idle defaults.

Writes use a select code on `wr_sel_i`: 0 is control, 1 is configuration, 2 is status. The live count is visible on `cnt_o`.

Top module: `win_wdog`

## Requirements
- R1: After `rst_ni`, `cnt_o` is 0x7F, `wdt_rst_o` and `irq_o` are 0, and the counter does not move.
- R2: While armed, the counter decrements once every 2^FIX_DIV_W * 2^P clock cycles. P is the prescaler exponent in configuration bits [9:7]: bits [8:7] by default, and all three bits when EXT_PRESC is set. While not armed the counter holds.
- R3: On the tick where the counter steps from 0x40, `wdt_rst_o` pulses in the following cycle. The number of ticks from a load until that reset equals the loaded low six bits plus one.
- R4: A control write whose counter field (bits [6:0]) has bit 6 clear causes a reset pulse in the next cycle. This applies when the block is armed or when the write sets the enable bit (bit 7).
- R5: A control write while armed, when the current count is greater than the window (configuration bits [6:0]), causes a reset pulse in the next cycle.
- R6: A control write while armed, with the count at or below the window and bit 6 of the new value set, loads the new value and raises no reset.
- R7: A control write with bit 7 clear never disarms an armed watchdog.
- R8: The warning flag sets on the tick where the counter reaches 0x40. It holds until a status write with bit 0 set. `irq_o` is the flag gated by configuration bit 10.
- R9: `wdt_rst_o` is one cycle wide. In that cycle the block is disarmed, the counter reads 0x7F, the window is 0x7F, and the prescaler, interrupt enable and flag are cleared.
- R10: A control write while not armed, with bit 7 clear, loads any value including those below 0x40, without a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Target: 0 control, 1 configuration, 2 status |
| wr_data_i | input | 16 | Write data |
| cnt_o | output | 7 | Current counter value |
| irq_o | output | 1 | Early-warning interrupt |
| wdt_rst_o | output | 1 | One-cycle system reset request |

## Verification
The bench races refreshes against the count at random points around a random window. A design that compared the window with the new value instead of the current count, or used a non-strict compare, would reset on legal refreshes or let early ones pass. It measures the spacing of decrements for several exponents, where an off-by-one in the prescaler mask would show as a doubled or halved period. It also times the expiry after a small load, which catches a counter that expires at 0x40 instead of one tick later. Finally it tries to disarm with bit 7 clear and loads low values while idle, which separates a sticky enable from a plain register and shows whether the below-range check is gated by the armed state.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int CNT_W = 7;
  localparam int DATA_W = 16;
  localparam logic [CNT_W-1:0] CNT_INIT = 7'h7F;
  localparam logic [CNT_W-1:0] CNT_FLOOR = 7'h40;
  localparam logic [CNT_W-1:0] CNT_WARN = 7'h41;
  localparam int CTRL_EN_BIT = 7;
  localparam int CFG_EXP_LSB = 7;
  localparam int CFG_IE_BIT = 10;
  localparam int STAT_CLR_BIT = 0;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_CFG  = 2'd1,
    SEL_STAT = 2'd2
  } wsel_e;
endpackage

// File: rtl/wdog_tick_gen.sv
module wdog_tick_gen #(
  parameter int FIX_DIV_W = 12,
  parameter int EXP_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [EXP_W-1:0] exp_i,
  output logic             tick_o
);
  localparam int PRE_W = (1 << EXP_W) - 1;

  logic [FIX_DIV_W-1:0] fix_q;
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] sel_mask;
  logic fix_wrap;

  assign fix_wrap = &fix_q;

  // mask bit i is set when the selected exponent exceeds i
  for (genvar i = 0; i < PRE_W; i++) begin : g_mask
    assign sel_mask[i] = (int'(exp_i) > i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fix_q <= '0;
      pre_q <= '0;
    end else begin
      fix_q <= fix_q + 1'b1;
      if (fix_wrap) pre_q <= pre_q + 1'b1;
    end
  end

  assign tick_o = fix_wrap && ((pre_q & sel_mask) == sel_mask);

  AST_TICK_ISOLATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o); // R2
endmodule

// File: rtl/wdog_cfg.sv
module wdog_cfg
  import wdog_pkg::*;
#(
  parameter int EXP_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              flag_set_i,
  output logic [CNT_W-1:0]  win_o,
  output logic [EXP_W-1:0]  exp_o,
  output logic              irq_o
);
  logic cfg_wr, stat_clr;
  logic ie_q, flag_q;
  logic [CNT_W-1:0] win_q;
  logic [EXP_W-1:0] exp_q;

  assign cfg_wr = wr_en_i && (wr_sel_i == SEL_CFG);
  assign stat_clr = wr_en_i && (wr_sel_i == SEL_STAT) && wr_data_i[STAT_CLR_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q <= CNT_INIT;
      exp_q <= '0;
      ie_q <= 1'b0;
    end else if (clr_i) begin
      win_q <= CNT_INIT;
      exp_q <= '0;
      ie_q <= 1'b0;
    end else if (cfg_wr) begin
      win_q <= wr_data_i[CNT_W-1:0];
      exp_q <= wr_data_i[CFG_EXP_LSB +: EXP_W];
      ie_q <= wr_data_i[CFG_IE_BIT];
    end
  end

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else if (clr_i) flag_q <= 1'b0;
    else if (flag_set_i) flag_q <= 1'b1;
    else if (stat_clr) flag_q <= 1'b0;
  end

  assign win_o = win_q;
  assign exp_o = exp_q;
  assign irq_o = flag_q && ie_q;

  AST_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q && !clr_i && !stat_clr |=> flag_q); // R8
  AST_FLAG_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_clr && !flag_set_i |=> !irq_o); // R8
endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [CNT_W-1:0]  win_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              rst_req_o,
  output logic              flag_set_o,
  output logic              wdt_rst_o
);
  logic en_q, rst_q;
  logic [CNT_W-1:0] cnt_q, wr_cnt;
  logic ctrl_wr, early_hit, low_hit, expire_hit, step;

  always_comb begin
    ctrl_wr = wr_en_i && (wr_sel_i == SEL_CTRL);
    wr_cnt = wr_data_i[CNT_W-1:0];
    early_hit = ctrl_wr && en_q && (cnt_q > win_i);
    low_hit = ctrl_wr && (en_q || wr_data_i[CTRL_EN_BIT]) && !wr_cnt[CNT_W-1];
    // a refresh takes priority over a coincident tick
    step = en_q && tick_i && !ctrl_wr;
    expire_hit = step && (cnt_q == CNT_FLOOR);
    rst_req_o = early_hit || low_hit || expire_hit;
    flag_set_o = step && (cnt_q == CNT_WARN);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0;
      cnt_q <= CNT_INIT;
      rst_q <= 1'b0;
    end else begin
      rst_q <= rst_req_o;
      if (rst_req_o) begin
        en_q <= 1'b0;
        cnt_q <= CNT_INIT;
      end else if (ctrl_wr) begin
        en_q <= en_q || wr_data_i[CTRL_EN_BIT];
        cnt_q <= wr_cnt;
      end else if (step) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign cnt_o = cnt_q;
  assign wdt_rst_o = rst_q;

  AST_STEP_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step && !rst_req_o |=> cnt_q == $past(cnt_q) - 7'd1); // R2
  AST_FROZEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q && !ctrl_wr |=> $stable(cnt_q)); // R2
  AST_EN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q |=> en_q || rst_q); // R7
  AST_ARMED_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q |-> cnt_q[CNT_W-1]); // R4
  AST_PULSE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_q |=> !rst_q); // R9
  AST_PULSE_DEFAULTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_q |-> !en_q && cnt_q == CNT_INIT); // R9
endmodule

// File: rtl/win_wdog.sv
module win_wdog
  import wdog_pkg::*;
#(
  parameter int FIX_DIV_W = 12,
  parameter bit EXT_PRESC = 1'b0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [1:0]  wr_sel_i,
  input  logic [15:0] wr_data_i,
  output logic [6:0]  cnt_o,
  output logic        irq_o,
  output logic        wdt_rst_o
);
  localparam int EXP_W = EXT_PRESC ? 3 : 2;

  logic tick, rst_req, flag_set;
  logic [CNT_W-1:0] win;
  logic [EXP_W-1:0] exp_sel;

  wdog_tick_gen #(.FIX_DIV_W(FIX_DIV_W), .EXP_W(EXP_W)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .exp_i(exp_sel), .tick_o(tick)
  );

  wdog_cfg #(.EXP_W(EXP_W)) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(rst_req),
    .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
    .flag_set_i(flag_set), .win_o(win), .exp_o(exp_sel), .irq_o(irq_o)
  );

  wdog_core u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick),
    .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
    .win_i(win), .cnt_o(cnt_o), .rst_req_o(rst_req),
    .flag_set_o(flag_set), .wdt_rst_o(wdt_rst_o)
  );

  AST_IRQ_QUIET_ON_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |-> !irq_o); // R9
endmodule

// File: tb/win_wdog_tb.sv
module win_wdog_tb;
  localparam int FDW = 3;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_en_i = 1'b0;
  logic [1:0] wr_sel_i = 2'd0;
  logic [15:0] wr_data_i = '0;
  logic [6:0] cnt_o;
  logic irq_o, wdt_rst_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  win_wdog #(.FIX_DIV_W(FDW)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_data_i(wr_data_i), .cnt_o(cnt_o), .irq_o(irq_o), .wdt_rst_o(wdt_rst_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_reset(bit armed, int cur, int win, logic [7:0] d);
    return (armed && cur > win) || ((armed || d[7]) && !d[6]);
  endfunction

  function automatic logic [15:0] cfg_word(int win, int p, bit ie);
    logic [15:0] w;
    w = '0;
    w[6:0] = 7'(win);
    w[9:7] = 3'(p);
    w[10] = ie;
    return w;
  endfunction

  // called at a negedge; returns one negedge later
  task automatic wr_now(input logic [1:0] sel, input logic [15:0] d);
    wr_en_i = 1'b1;
    wr_sel_i = sel;
    wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk_i);
    wr_now(sel, d);
  endtask

  task automatic measure_period(input int p);
    int k;
    logic [6:0] prev;
    wr(2'd1, cfg_word(7'h7F, p, 1'b0));
    wr(2'd0, 16'h00FF);
    prev = cnt_o;
    while (cnt_o == prev) @(negedge clk_i);
    prev = cnt_o;
    k = 0;
    while (cnt_o == prev) begin
      @(negedge clk_i);
      k++;
    end
    chk(k == (8 << p), "R2 period", k, 8 << p);
    wr(2'd0, 16'h0000);
    chk(wdt_rst_o == 1'b1, "R4 low write armed", wdt_rst_o, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog act=0 exp=1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int k;
    logic [6:0] prev;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk(cnt_o == 7'h7F, "R1 cnt", cnt_o, 7'h7F);
    chk(wdt_rst_o == 1'b0 && irq_o == 1'b0, "R1 outs", {wdt_rst_o, irq_o}, 0);
    repeat (100) @(negedge clk_i);
    chk(cnt_o == 7'h7F, "R1 idle hold", cnt_o, 7'h7F);

    // R10 low load while idle
    wr(2'd0, 16'h0010);
    chk(wdt_rst_o == 1'b0, "R10 no reset", wdt_rst_o, 0);
    chk(cnt_o == 7'h10, "R10 load", cnt_o, 7'h10);
    repeat (50) @(negedge clk_i);
    chk(cnt_o == 7'h10, "R2 idle no count", cnt_o, 7'h10);

    // R2 periods
    measure_period(1);
    measure_period(2);
    measure_period(0);

    // R7 sticky enable
    wr(2'd1, cfg_word(7'h7F, 0, 1'b0));
    wr(2'd0, 16'h00FF);
    wr(2'd0, 16'h007F);
    chk(wdt_rst_o == 1'b0, "R6 legal refresh", wdt_rst_o, 0);
    repeat (20) @(negedge clk_i);
    chk(cnt_o < 7'h7F, "R7 still counting", cnt_o, 7'h7E);
    wr(2'd0, 16'h0000);
    chk(wdt_rst_o == 1'b1, "R7 still armed", wdt_rst_o, 1);

    // R3 / R8 expiry timing and flag
    @(negedge clk_i);
    wr(2'd1, cfg_word(7'h7F, 0, 1'b1));
    wr(2'd0, 16'h00C2);
    k = 0;
    while (!wdt_rst_o && k < 100) begin
      if (cnt_o == 7'h40)
        chk(irq_o == 1'b1, "R8 flag at 0x40", irq_o, 1);
      @(negedge clk_i);
      k++;
    end
    chk(k > 16 && k <= 24, "R3 expiry time", k, 24);
    chk(cnt_o == 7'h7F && irq_o == 1'b0, "R9 defaults in pulse", {irq_o, cnt_o}, 7'h7F);
    @(negedge clk_i);
    chk(wdt_rst_o == 1'b0, "R9 single cycle", wdt_rst_o, 0);
    repeat (40) @(negedge clk_i);
    chk(cnt_o == 7'h7F, "R9 disarmed", cnt_o, 7'h7F);
    // default window 0x7F lets an immediate refresh pass
    wr(2'd0, 16'h00FF);
    wr(2'd0, 16'h007F);
    chk(wdt_rst_o == 1'b0, "R9 window default", wdt_rst_o, 0);
    wr(2'd0, 16'h0000);
    chk(wdt_rst_o == 1'b1, "R4 forced", wdt_rst_o, 1);

    // R8 gating and clear
    @(negedge clk_i);
    wr(2'd1, cfg_word(7'h7F, 3, 1'b0));
    wr(2'd0, 16'h00C1);
    k = 0;
    while (cnt_o != 7'h40 && k < 200) begin
      @(negedge clk_i);
      k++;
    end
    chk(irq_o == 1'b0, "R8 gated off", irq_o, 0);
    wr(2'd1, cfg_word(7'h7F, 3, 1'b1));
    chk(irq_o == 1'b1, "R8 gated on", irq_o, 1);
    wr(2'd2, 16'h0001);
    chk(irq_o == 1'b0, "R8 cleared", irq_o, 0);
    wr(2'd0, 16'h007F);
    chk(wdt_rst_o == 1'b0 && cnt_o == 7'h7F, "R6 refresh at floor", cnt_o, 7'h7F);
    wr(2'd0, 16'h0000);

    // R5 early refresh
    @(negedge clk_i);
    wr(2'd1, cfg_word(7'h50, 0, 1'b0));
    wr(2'd0, 16'h00FF);
    wr(2'd0, 16'h007F);
    chk(wdt_rst_o == 1'b1, "R5 early refresh", wdt_rst_o, 1);

    // random refresh races
    for (int it = 0; it < 40; it++) begin
      int p, w, c, lim, nw, cur;
      logic [7:0] d;
      bit e;
      @(negedge clk_i);
      p = $urandom % 3;
      w = 7'h40 + ($urandom % 64);
      c = 7'h40 + ($urandom % 64);
      wr(2'd1, cfg_word(w, p, 1'b0));
      wr(2'd0, 16'(8'h80 | c));
      chk(wdt_rst_o == 1'b0 && cnt_o == 7'(c), "R6 arm load", cnt_o, c);
      lim = (c & 8'h3F) * (8 << p);
      if (lim > 300) lim = 300;
      nw = (lim == 0) ? 0 : ($urandom % lim);
      repeat (nw) @(negedge clk_i);
      @(negedge clk_i);
      cur = int'(cnt_o);
      if (($urandom % 4) == 0) d = 8'($urandom % 256);
      else d = 8'(($urandom % 2) << 7) | 8'(8'h40 + ($urandom % 64));
      e = exp_reset(1'b1, cur, w, d);
      wr_now(2'd0, {8'h00, d});
      chk(wdt_rst_o == e, e ? "R5 R4 random reset" : "R6 random refresh", wdt_rst_o, e);
      if (!e) begin
        chk(cnt_o == d[6:0], "R6 random load", cnt_o, d[6:0]);
        wr(2'd0, 16'h0000);
        chk(wdt_rst_o == 1'b1, "R4 random forced", wdt_rst_o, 1);
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule